// File: doc/BRIEF.md
# Lockable SMRAM Control Register

This block holds the two configuration bytes that govern access to system-management memory: a main control byte with open, close, lock and global-enable bits, and an extended byte with a TSEG-enable bit and a two-bit TSEG size code. Software reaches both through a simple byte-wide configuration port. The port has an address, a write strobe, write data and combinational read data. From the stored bits and one SMM-active input, the block derives the enables that a neighbouring address decoder uses to route the low SMRAM window and the TSEG window.

Firmware normally opens the window to load handler code, then closes it, then sets the lock bit. Setting lock clears the open bit in the same write. From then on the open bit cannot be raised again, and the lock itself cannot be cleared. The global enable and the whole extended byte also freeze. Only the synchronous reset removes the lock. The close bit stays writable after lock so that SMM code can still switch between code and data views.

Top module: `smram_ctl_top`

## Requirements
- R1: After reset, both bytes read 0x00: open, close, lock, global enable and TSEG enable are 0, and the size field holds code 0, the 1 MB encoding.
- R2: While unlocked, writes to the main byte (default address 0x9D) store open (bit 6), close (bit 5) and global enable (bit 3), and a read returns them. Bits 7, 2, 1 and 0 read 0.
- R3: A main-byte write with lock (bit 4) set stores lock = 1 and forces open to 0 in that same write, whatever the written open bit.
- R4: Once locked, a write of 1 to the open bit leaves it reading 0, and a write of 0 to the lock bit leaves lock at 1.
- R5: Once locked, the global-enable bit and the entire extended byte ignore writes, while the close bit remains writable.
- R6: While unlocked, the extended byte (default address 0x9E) stores TSEG enable in bit 0 and the size code in bits 2:1 (0 = 1 MB, 1 = 2 MB, 2 = 8 MB, 3 = extended size). Bits 7:3 read 0.
- R7: Reads of any other address return 0x00, and writes to any other address change neither byte.
- R8: Reset clears the lock, after which the open bit can be set and cleared again.
- R9: `low_win_en` equals global enable AND (open OR (SMM active AND NOT close)).
- R10: `tseg_win_en` equals global enable AND TSEG enable AND SMM active, `tseg_size` mirrors the stored size code, and `smram_locked` mirrors the lock bit.
- R11: A write takes effect at the clock edge that samples it. Read data and decoded outputs reflect the new state right after that edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears the lock |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_we | input | 1 | Write strobe for the addressed byte |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Combinational read data for cfg_addr |
| smm_act | input | 1 | Processor is in system-management mode |
| low_win_en | output | 1 | Route the low SMRAM window to memory |
| tseg_win_en | output | 1 | Route the TSEG window to memory |
| tseg_size | output | 2 | Stored TSEG size code |
| smram_locked | output | 1 | Lock bit state |

## Verification
Every register update lands at the edge that samples the write. Read data and the decoded window enables are combinational from the registers and from `smm_act`, so each result is due in the same cycle, just after that edge. The bench drives inputs at the falling edge and updates its reference model for the rising edge. It then compares all outputs one time unit after the rising edge, before the inputs change again. Directed sequences cover the lock handshake, reset release and unmapped addresses. A long stretch of mixed traffic follows, with occasional resets.

// File: rtl/smram_pkg.sv
package smram_pkg;

    localparam int CFG_DW = 8;

    typedef enum logic [1:0] {
        TSEG_1M  = 2'd0,
        TSEG_2M  = 2'd1,
        TSEG_8M  = 2'd2,
        TSEG_EXT = 2'd3
    } tseg_code_e;

    typedef struct packed {
        logic open;
        logic cls;
        logic lck;
        logic gen;
    } smram_ctl_t;

    typedef struct packed {
        logic       ten;
        tseg_code_e sz;
    } smram_ext_t;

    localparam smram_ctl_t CTL_RESET = '{open: 1'b0, cls: 1'b0, lck: 1'b0, gen: 1'b0};
    localparam smram_ext_t EXT_RESET = '{ten: 1'b0, sz: TSEG_1M};

    function automatic logic low_window(input smram_ctl_t c, input logic smm);
        return c.gen & (c.open | (smm & ~c.cls));
    endfunction

    function automatic logic tseg_window(input smram_ctl_t c, input smram_ext_t e,
                                         input logic smm);
        return c.gen & e.ten & smm;
    endfunction

endpackage

// File: rtl/smram_addr_dec.sv
module smram_addr_dec #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] MAIN_ADDR = 8'h9D,
    parameter logic [ADDR_W-1:0] EXT_ADDR  = 8'h9E
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              sel_main,
    output logic              sel_ext
);
    always_comb begin
        sel_main = (addr == MAIN_ADDR);
        sel_ext  = (addr == EXT_ADDR);
    end

    // R7: at most one byte is ever selected
    always_comb begin
        a_r7_one_select: assert ($onehot0({sel_main, sel_ext}))
            else $error("address decode selects two bytes");
    end
endmodule

// File: rtl/smram_ctl_reg.sv
module smram_ctl_reg
    import smram_pkg::*;
#(
    parameter int OPEN_BIT = 6,
    parameter int CLS_BIT  = 5,
    parameter int LCK_BIT  = 4,
    parameter int GEN_BIT  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CFG_DW-1:0] wdata,
    output smram_ctl_t        ctl_q
);
    smram_ctl_t ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d.cls = wdata[CLS_BIT];
            if (!ctl_q.lck) begin
                ctl_d.lck  = wdata[LCK_BIT];
                ctl_d.gen  = wdata[GEN_BIT];
                ctl_d.open = wdata[LCK_BIT] ? 1'b0 : wdata[OPEN_BIT];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= CTL_RESET;
        else     ctl_q <= ctl_d;
    end

    // R4: lock never drops without reset
    a_r4_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        ctl_q.lck |=> ctl_q.lck);
    // R3: a write carrying the lock bit leaves open clear
    a_r3_lock_clears_open: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata[LCK_BIT]) |=> (ctl_q.lck && !ctl_q.open));
    // R4: open cannot rise while locked
    a_r4_open_held_low: assert property (@(posedge clk) disable iff (rst)
        ctl_q.lck |=> !ctl_q.open);
    // R5: global enable frozen while locked
    a_r5_gen_frozen: assert property (@(posedge clk) disable iff (rst)
        ctl_q.lck |=> $stable(ctl_q.gen));
endmodule

// File: rtl/smram_ext_reg.sv
module smram_ext_reg
    import smram_pkg::*;
#(
    parameter int TEN_BIT = 0,
    parameter int SZ_LSB  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              locked,
    input  logic [CFG_DW-1:0] wdata,
    output smram_ext_t        ext_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q <= EXT_RESET;
        end else if (wr_en && !locked) begin
            ext_q.ten <= wdata[TEN_BIT];
            ext_q.sz  <= tseg_code_e'(wdata[SZ_LSB +: 2]);
        end
    end

    // R5: extended byte frozen while locked
    a_r5_ext_frozen: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(ext_q));
endmodule

// File: rtl/smram_route.sv
module smram_route
    import smram_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  smram_ctl_t ctl,
    input  smram_ext_t ext,
    input  logic       smm,
    output logic       low_en,
    output logic       tseg_en,
    output logic [1:0] tseg_sz
);
    always_comb begin
        low_en  = low_window(ctl, smm);
        tseg_en = tseg_window(ctl, ext, smm);
        tseg_sz = ext.sz;
    end

    // R10: the TSEG window only ever opens inside SMM
    a_r10_tseg_needs_smm: assert property (@(posedge clk) disable iff (rst)
        tseg_en |-> smm);
    // R9: outside SMM the low window needs the open bit
    a_r9_low_outside_smm: assert property (@(posedge clk) disable iff (rst)
        (low_en && !smm) |-> ctl.open);
endmodule

// File: rtl/smram_ctl_top.sv
module smram_ctl_top
    import smram_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] MAIN_ADDR = 8'h9D,
    parameter logic [ADDR_W-1:0] EXT_ADDR  = 8'h9E,
    parameter int                OPEN_BIT  = 6,
    parameter int                CLS_BIT   = 5,
    parameter int                LCK_BIT   = 4,
    parameter int                GEN_BIT   = 3,
    parameter int                TEN_BIT   = 0,
    parameter int                SZ_LSB    = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_we,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic [CFG_DW-1:0] cfg_rdata,
    input  logic              smm_act,
    output logic              low_win_en,
    output logic              tseg_win_en,
    output logic [1:0]        tseg_size,
    output logic              smram_locked
);
    logic       sel_main, sel_ext;
    smram_ctl_t ctl_q;
    smram_ext_t ext_q;

    smram_addr_dec #(.ADDR_W(ADDR_W), .MAIN_ADDR(MAIN_ADDR), .EXT_ADDR(EXT_ADDR)) u_dec (
        .addr(cfg_addr), .sel_main(sel_main), .sel_ext(sel_ext)
    );

    smram_ctl_reg #(.OPEN_BIT(OPEN_BIT), .CLS_BIT(CLS_BIT), .LCK_BIT(LCK_BIT),
                    .GEN_BIT(GEN_BIT)) u_ctl (
        .clk(clk), .rst(rst), .wr_en(cfg_we && sel_main), .wdata(cfg_wdata), .ctl_q(ctl_q)
    );

    smram_ext_reg #(.TEN_BIT(TEN_BIT), .SZ_LSB(SZ_LSB)) u_ext (
        .clk(clk), .rst(rst), .wr_en(cfg_we && sel_ext), .locked(ctl_q.lck),
        .wdata(cfg_wdata), .ext_q(ext_q)
    );

    smram_route u_route (
        .clk(clk), .rst(rst), .ctl(ctl_q), .ext(ext_q), .smm(smm_act),
        .low_en(low_win_en), .tseg_en(tseg_win_en), .tseg_sz(tseg_size)
    );

    always_comb begin
        cfg_rdata = '0;
        if (sel_main) begin
            cfg_rdata[OPEN_BIT] = ctl_q.open;
            cfg_rdata[CLS_BIT]  = ctl_q.cls;
            cfg_rdata[LCK_BIT]  = ctl_q.lck;
            cfg_rdata[GEN_BIT]  = ctl_q.gen;
        end else if (sel_ext) begin
            cfg_rdata[TEN_BIT]       = ext_q.ten;
            cfg_rdata[SZ_LSB +: 2]   = ext_q.sz;
        end
        smram_locked = ctl_q.lck;
    end

    // R7: unmapped addresses read zero
    a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (!sel_main && !sel_ext) |-> (cfg_rdata == '0));
endmodule

// File: tb/smram_ctl_top_tb_top.sv
module smram_ctl_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cfg_addr = 8'h00;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       smm_act = 1'b0;
    logic       low_win_en, tseg_win_en, smram_locked;
    logic [1:0] tseg_size;

    int applied = 0;
    int bad = 0;
    bit done = 0;

    // reference state
    bit m_open, m_cls, m_lck, m_gen, m_ten;
    int m_sz;

    always #(CLK_PERIOD/2) clk = ~clk;

    smram_ctl_top dut_i (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .smm_act(smm_act),
        .low_win_en(low_win_en), .tseg_win_en(tseg_win_en),
        .tseg_size(tseg_size), .smram_locked(smram_locked)
    );

    function automatic int exp_rd(input int a);
        if (a == 'h9D) return (m_open << 6) | (m_cls << 5) | (m_lck << 4) | (m_gen << 3);
        if (a == 'h9E) return (m_sz << 1) | m_ten;
        return 0;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        applied++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input int a, input bit we, input int d, input bit s,
                       input bit r, input string tag);
        @(negedge clk);
        cfg_addr = 8'(a); cfg_we = we; cfg_wdata = 8'(d); smm_act = s; rst = r;
        @(posedge clk);
        #1;
        if (r) begin
            {m_open, m_cls, m_lck, m_gen, m_ten} = '0; m_sz = 0;
        end else if (we && a == 'h9D) begin
            m_cls = d[5];
            if (!m_lck) begin
                m_lck = d[4]; m_gen = d[3];
                m_open = d[4] ? 1'b0 : d[6];
            end
        end else if (we && a == 'h9E && !m_lck) begin
            m_ten = d[0]; m_sz = (d >> 1) & 3;
        end
        check(tag, "rdata", int'(cfg_rdata), exp_rd(a));
        check("R9", "low_win_en", int'(low_win_en), int'(m_gen & (m_open | (s & ~m_cls))));
        check("R10", "tseg_win_en", int'(tseg_win_en), int'(m_gen & m_ten & s));
        check("R10", "tseg_size", int'(tseg_size), m_sz);
        check("R10", "smram_locked", int'(smram_locked), int'(m_lck));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end

    initial begin
        // R1 reset values
        cyc('h9D, 0, 0, 0, 1, "R1");
        cyc('h9D, 0, 0, 0, 0, "R1");
        cyc('h9E, 0, 0, 0, 0, "R1");
        // R2 open set and clear while unlocked; R11 immediate visibility
        cyc('h9D, 1, 'h40, 0, 0, "R2");
        cyc('h9D, 1, 'h00, 0, 0, "R11");
        cyc('h9D, 1, 'hC7, 0, 0, "R2");
        cyc('h9D, 1, 'h28, 0, 0, "R2");
        // R9 window combinations
        cyc('h9D, 0, 0, 1, 0, "R9");
        cyc('h9D, 1, 'h08, 1, 0, "R9");
        cyc('h9D, 1, 'h48, 0, 0, "R9");
        // R6 extended byte
        cyc('h9E, 1, 'h05, 1, 0, "R6");
        cyc('h9E, 1, 'hFF, 1, 0, "R6");
        cyc('h9E, 1, 'h02, 0, 0, "R6");
        // R7 unmapped
        cyc('h9C, 1, 'hFF, 0, 0, "R7");
        cyc('h00, 0, 0, 0, 0, "R7");
        cyc('h9D, 0, 0, 0, 0, "R7");
        cyc('h9E, 0, 0, 0, 0, "R7");
        // R3 lock with open requested
        cyc('h9D, 1, 'h48, 0, 0, "R3");
        cyc('h9D, 1, 'h58, 0, 0, "R3");
        // R4 open and lock held
        cyc('h9D, 1, 'h40, 0, 0, "R4");
        cyc('h9D, 1, 'h00, 0, 0, "R4");
        cyc('h9D, 1, 'hFF, 1, 0, "R4");
        // R5 gen and ext frozen, close writable
        cyc('h9E, 1, 'h07, 0, 0, "R5");
        cyc('h9E, 0, 0, 0, 0, "R5");
        cyc('h9D, 1, 'h20, 1, 0, "R5");
        cyc('h9D, 1, 'h00, 1, 0, "R5");
        // R8 reset releases lock
        cyc('h9D, 0, 0, 0, 1, "R8");
        cyc('h9D, 1, 'h40, 0, 0, "R8");
        cyc('h9D, 1, 'h00, 0, 0, "R8");
        cyc('h9D, 1, 'h40, 0, 0, "R8");
        // mixed traffic
        for (int i = 0; i < 3000; i++) begin
            int sel = $urandom_range(0, 9);
            int a = (sel < 5) ? 'h9D : (sel < 8) ? 'h9E : (sel == 8) ? 'h9C : 'h9F;
            bit r = ($urandom_range(0, 59) == 0);
            cyc(a, bit'($urandom_range(0, 1)), int'($urandom_range(0, 255)),
                bit'($urandom_range(0, 1)), r, "R11");
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end
endmodule